// File: doc/BRIEF.md
# Pipelined Three-Product Recursive Multiplier

This block multiplies two unsigned operands of WIDTH bits and returns the exact product of 2·WIDTH bits. At each level it cuts both operands into an upper and a lower half. It forms only three half-width products: upper×upper, lower×lower, and the product of the two half sums. It then rebuilds the full product from those three with shifts and adds.

The half-width products come from the same structure, one level down. The recursion stops at 16×16 multipliers that take one clock each. A 32-bit unit therefore holds 3 base multipliers and a 64-bit unit holds 9. The pipeline takes a new operand pair on every clock. Each result appears a fixed number of cycles later, flagged by out_valid.

The half sums are one bit wider than a half. Their carry bits are not passed to wider multipliers. They are folded back in through small correction terms, so every sub-multiplier stays exactly half the width of its parent. The final recombining adder is cut into a lower and an upper registered half.

Top module: `dc_mult`

## Requirements
- R1: When out_valid is 1, product equals the unsigned product of the a and b that were presented with in_valid high exactly LAT cycles earlier. This holds for any operand values, including when valid inputs arrive with gaps between them.
- R2: The latency is LAT = 1 + 6·k cycles, where k is the number of halvings from WIDTH down to 16 (LAT is 7 for WIDTH 32 and 13 for WIDTH 64). out_valid is 1 in a cycle exactly when in_valid was 1 LAT cycles before.
- R3: A new operand pair is accepted on every clock. An unbroken stream of valid inputs yields an unbroken stream of correct products, in input order.
- R4: Operands presented while in_valid is 0 have no effect on any output. In every cycle where out_valid is 0, product reads all zeros.
- R5: While rst_n is 0 (synchronous, active low), out_valid is 0 and product is all zeros from the next clock edge on. No result from before the reset emerges afterwards.
- R6: The result is exact for operands whose half sums carry out of a half. This covers all-ones operands, 2^(WIDTH/2), 2^(WIDTH/2)−1, the top bit alone, the upper half all ones, alternating bits, 0 and 1, in every pairing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks a and b as a pair to multiply in this cycle |
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | Marks product as a finished result |
| product | output | 2*WIDTH | Unsigned product; zero when out_valid is 0 |

## Verification
In the same cycle, the block can accept a fresh operand pair and release a finished product, or it can receive garbage operands with in_valid low while a finished product leaves. A gapped stream provokes this: random in_valid patterns run over random operands, so accepted, ignored and emerging pairs overlap in every combination. Both a 32-bit and a 64-bit instance are judged at every cycle. out_valid is compared with the input flag from LAT cycles before. product is compared with the arithmetic product of the operands recorded from that cycle, or with zero.

// File: rtl/dc_mult_pkg.sv
package dc_mult_pkg;

  localparam int BASE_W = 16;
  localparam int LEVEL_STAGES = 6;

  // Pipeline depth for a given operand width: one cycle at the base,
  // plus a fixed overhead per halving.
  function automatic int kmulLatency(input int w);
    int lat;
    int x;
    lat = 1;
    x = w;
    while (x > BASE_W) begin
      lat = lat + LEVEL_STAGES;
      x = x / 2;
    end
    return lat;
  endfunction

  typedef struct packed {
    logic capture;  // current operands belong to a real request
    logic done;     // pipeline output belongs to a real request
  } dc_strobe_t;

endpackage

// File: rtl/dc_mult_delay.sv
module dc_mult_delay #(
  parameter int W = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/dc_mult_node.sv
module dc_mult_node
  import dc_mult_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  generate
    if (W <= BASE_W) begin : g_base
      logic [2*W-1:0] pReg;
      always_ff @(posedge clk) begin
        if (!rst_n) pReg <= '0;
        else        pReg <= {{W{1'b0}}, x} * {{W{1'b0}}, y};
      end
      assign p = pReg;
    end else begin : g_split
      localparam int H = W / 2;
      localparam int SUB_LAT = kmulLatency(H);

      // stage 1: halves, half sums and carry corrections
      logic [H:0]   xSum, ySum, corrComb;
      logic         ccComb;
      assign xSum = {1'b0, x[W-1:H]} + {1'b0, x[H-1:0]};
      assign ySum = {1'b0, y[W-1:H]} + {1'b0, y[H-1:0]};
      assign corrComb = (xSum[H] ? {1'b0, ySum[H-1:0]} : '0)
                      + (ySum[H] ? {1'b0, xSum[H-1:0]} : '0);
      assign ccComb = xSum[H] & ySum[H];

      logic [H-1:0] xHi, xLo, yHi, yLo, xSumLo, ySumLo;
      logic [H:0]   corr1;
      logic         cc1;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          xHi <= '0; xLo <= '0; yHi <= '0; yLo <= '0;
          xSumLo <= '0; ySumLo <= '0; corr1 <= '0; cc1 <= 1'b0;
        end else begin
          xHi <= x[W-1:H]; xLo <= x[H-1:0];
          yHi <= y[W-1:H]; yLo <= y[H-1:0];
          xSumLo <= xSum[H-1:0]; ySumLo <= ySum[H-1:0];
          corr1 <= corrComb; cc1 <= ccComb;
        end
      end

      // three half-width products
      logic [W-1:0] t0, t1, t2l;
      dc_mult_node #(.W(H)) u_hi  (.clk(clk), .rst_n(rst_n), .x(xHi),    .y(yHi),    .p(t0));
      dc_mult_node #(.W(H)) u_lo  (.clk(clk), .rst_n(rst_n), .x(xLo),    .y(yLo),    .p(t1));
      dc_mult_node #(.W(H)) u_sum (.clk(clk), .rst_n(rst_n), .x(xSumLo), .y(ySumLo), .p(t2l));

      logic [H:0] corrD;
      logic       ccD;
      dc_mult_delay #(.W(H+2), .DEPTH(SUB_LAT)) u_corrDly (
        .clk(clk), .rst_n(rst_n), .d({cc1, corr1}), .q({ccD, corrD}));

      // stages 2..6: rebuild the full product
      logic [W+1:0] t2Full, t2P2;
      logic [W:0]   s01, mid;
      logic [W-1:0] t0P1, t1P1, t0P2, t1P2, t0P3, t1P3, t0P4, lowBits;
      logic [H:0]   midHi;
      logic         carry4;
      logic [W:0]   lowSum;
      logic [2*W-1:0] pReg;

      assign lowSum = {1'b0, t1P3} + {1'b0, mid[H-1:0], {H{1'b0}}};

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          t2Full <= '0; t0P1 <= '0; t1P1 <= '0;
          s01 <= '0; t2P2 <= '0; t0P2 <= '0; t1P2 <= '0;
          mid <= '0; t0P3 <= '0; t1P3 <= '0;
          lowBits <= '0; carry4 <= 1'b0; t0P4 <= '0; midHi <= '0;
          pReg <= '0;
        end else begin
          t2Full <= {2'b0, t2l}
                  + ({{(H+1){1'b0}}, corrD} << H)
                  + ({{(W+1){1'b0}}, ccD} << W);
          t0P1 <= t0; t1P1 <= t1;
          s01  <= {1'b0, t0P1} + {1'b0, t1P1};
          t2P2 <= t2Full; t0P2 <= t0P1; t1P2 <= t1P1;
          mid  <= t2P2[W:0] - s01;
          t0P3 <= t0P2; t1P3 <= t1P2;
          lowBits <= lowSum[W-1:0];
          carry4  <= lowSum[W];
          t0P4    <= t0P3;
          midHi   <= mid[W:H];
          pReg <= {t0P4 + {{(W-H-1){1'b0}}, midHi} + {{(W-1){1'b0}}, carry4}, lowBits};
        end
      end
      assign p = pReg;
    end
  endgenerate
endmodule

// File: rtl/dc_mult_dp.sv
module dc_mult_dp
  import dc_mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dc_strobe_t         strobe,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] product
);
  logic [WIDTH-1:0]   aGate, bGate;
  logic [2*WIDTH-1:0] rootP;

  assign aGate = strobe.capture ? a : '0;
  assign bGate = strobe.capture ? b : '0;

  dc_mult_node #(.W(WIDTH)) u_root (
    .clk(clk), .rst_n(rst_n), .x(aGate), .y(bGate), .p(rootP));

  assign product = strobe.done ? rootP : '0;
endmodule

// File: rtl/dc_mult_ctrl.sv
module dc_mult_ctrl
  import dc_mult_pkg::*;
#(
  parameter int LAT = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output dc_strobe_t strobe
);
  logic [LAT-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (!rst_n) validPipe <= '0;
    else        validPipe <= {validPipe[LAT-2:0], in_valid};
  end

  assign strobe.capture = in_valid;
  assign strobe.done    = validPipe[LAT-1];
endmodule

// File: rtl/dc_mult.sv
module dc_mult
  import dc_mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic               out_valid,
  output logic [2*WIDTH-1:0] product
);
  localparam int LAT = kmulLatency(WIDTH);

  dc_strobe_t strobe;

  dc_mult_ctrl #(.LAT(LAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .strobe(strobe));

  dc_mult_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .a(a), .b(b), .product(product));

  assign out_valid = strobe.done;
endmodule

// File: rtl/dc_mult_chk.sv
module dc_mult_chk #(
  parameter int WIDTH = 32,
  parameter int LAT = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [WIDTH-1:0]   a,
  input logic [WIDTH-1:0]   b,
  input logic               out_valid,
  input logic [2*WIDTH-1:0] product
);
  logic [LAT-1:0]     vShadow;
  logic [2*WIDTH-1:0] pShadow [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vShadow <= '0;
      for (int i = 0; i < LAT; i++) pShadow[i] <= '0;
    end else begin
      vShadow <= {vShadow[LAT-2:0], in_valid};
      pShadow[0] <= {{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b};
      for (int i = 1; i < LAT; i++) pShadow[i] <= pShadow[i-1];
    end
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vShadow[LAT-1]);

  // R1
  product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> product == pShadow[LAT-1]);

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> product == '0);

  // R5
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && product == '0));
endmodule

bind dc_mult dc_mult_chk #(.WIDTH(WIDTH), .LAT(dc_mult_pkg::kmulLatency(WIDTH))) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
  .out_valid(out_valid), .product(product));

// File: tb/dc_mult_bench.sv
module dc_mult_bench;
  localparam int N   = 1800;
  localparam int L32 = 7;   // 1 + 6*1
  localparam int L64 = 13;  // 1 + 6*2

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic inV = 1'b0;
  logic [31:0] a32 = '0, b32 = '0;
  logic [63:0] a64 = '0, b64 = '0;
  logic        ov32, ov64;
  logic [63:0]  p32;
  logic [127:0] p64;

  dc_mult #(.WIDTH(32)) u_dc_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(inV), .a(a32), .b(b32),
    .out_valid(ov32), .product(p32));

  dc_mult #(.WIDTH(64)) u_dc_mult_w64 (
    .clk(clk), .rst_n(rst_n), .in_valid(inV), .a(a64), .b(b64),
    .out_valid(ov64), .product(p64));

  bit          sV   [N];
  logic [31:0] sA32 [N];
  logic [31:0] sB32 [N];
  logic [63:0] sA64 [N];
  logic [63:0] sB64 [N];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  function automatic logic [63:0] corner(input int k, input int w);
    logic [63:0] ones;
    int h;
    ones = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    h = w / 2;
    case (k)
      0: return 64'd0;
      1: return 64'd1;
      2: return ones;
      3: return 64'd1 << h;
      4: return (64'd1 << h) - 64'd1;
      5: return ones & 64'hAAAA_AAAA_AAAA_AAAA;
      6: return 64'd1 << (w - 1);
      default: return ones ^ ((64'd1 << h) - 64'd1);
    endcase
  endfunction

  function automatic string tagFor(input int s);
    if (s >= 8 && s < 72)       return "R6";
    if (s >= 100 && s < 1100)   return "R3";
    return "R1";
  endfunction

  task automatic judge(input string who, input int cyc, input int lat,
                       input logic gotV, input logic [127:0] gotP, input int w);
    bit expV;
    logic [127:0] expP;
    string vTag, pTag;
    int s;
    s = cyc - lat;
    expV = (s >= 0) ? sV[s] : 1'b0;
    expP = '0;
    if (expV) begin
      if (w == 32) expP = 128'(sA32[s]) * 128'(sB32[s]);
      else         expP = 128'(sA64[s]) * 128'(sB64[s]);
    end
    vTag = (cyc < 5) ? "R5" : "R2";
    pTag = (cyc < 5) ? "R5" : (expV ? tagFor(s) : "R4");
    checks++;
    if (gotV !== expV) begin
      errors++;
      $display("FAIL %s %s cycle %0d out_valid actual %b expected %b", vTag, who, cyc, gotV, expV);
    end
    checks++;
    if (gotP !== expP) begin
      errors++;
      $display("FAIL %s %s cycle %0d product actual %h expected %h", pTag, who, cyc, gotP, expP);
    end
  endtask

  initial begin
    for (int cyc = 0; cyc < N; cyc++) begin
      @(negedge clk);
      judge("w32", cyc, L32, ov32, {64'b0, p32}, 32);
      judge("w64", cyc, L64, ov64, p64, 64);

      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      sV[cyc]   = 1'b0;
      sA64[cyc] = rng;
      sB64[cyc] = {rng[31:0], rng[63:32]} ^ 64'h5A5A_0F0F_3C3C_9696;
      sA32[cyc] = sA64[cyc][47:16];
      sB32[cyc] = sB64[cyc][40:9];
      if (cyc >= 8 && cyc < 72) begin
        // R6: every pairing of carry-prone corner operands, back to back
        sV[cyc]   = 1'b1;
        sA32[cyc] = corner((cyc - 8) / 8, 32);
        sB32[cyc] = corner((cyc - 8) % 8, 32);
        sA64[cyc] = corner((cyc - 8) / 8, 64);
        sB64[cyc] = corner((cyc - 8) % 8, 64);
      end else if (cyc >= 100 && cyc < 1100) begin
        sV[cyc] = 1'b1;                  // R3 unbroken stream
      end else if (cyc >= 1100 && cyc < 1700) begin
        sV[cyc] = rng[37];               // R1/R4 gapped stream with garbage
      end

      rst_n = (cyc >= 4);
      inV   = sV[cyc];
      a32   = sA32[cyc];
      b32   = sB32[cyc];
      a64   = sA64[cyc];
      b64   = sB64[cyc];
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog expired, actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule